// File: doc/BRIEF.md
# Bonded Transmit Lane Prefill Sequencer

After the transmit digital reset is released, this block brings a group of soft-bonded transmit lanes into a common starting state. Each lane has its own FIFO. The sequencer writes into all of these FIFOs at the same time until every one of them reports full. It then waits for a frame boundary on any lane and stops writing on every lane in the same cycle. Finally it confirms that all lanes are still full, lets a fixed settle interval pass, and then reports that the bonded group is ready.

The lane count and the settle length are parameters. The full and frame-boundary flags of each lane are registered once in the core clock domain before any state decision uses them. Write enable (data-valid) and frame-burst enable are the same on every lane. The ready flag stays set until the next reset. After that point, frame-burst enable is handed to the lanes.

Top module: `tx_prefill_ctrl`

## Requirements
- R1: While rst_ni is low, data_valid_o, burst_en_o and done_o are all low, without waiting for a clock edge. Asserting reset at any point restarts the whole sequence.
- R2: After rst_ni rises, the first clock edge leaves data_valid_o low (a start cycle). The second edge drives data_valid_o high on every lane.
- R3: data_valid_o stays high while any lane's registered full flag is low. Frame-start pulses that arrive before every lane is full have no effect on it.
- R4: Once every lane is full, data_valid_o stays high until a frame-start pulse arrives on any lane. data_valid_o then falls on all lanes on the clock edge after the edge that samples the pulse.
- R5: data_valid_o carries the same value on every lane in every cycle, and it is never high while done_o is high.
- R6: The settle phase starts on the clock edge that follows the first edge, counted from the second edge after data-valid falls, at which every lane_full_i bit is sampled high. done_o rises 16 clock edges after the settle phase starts.
- R7: Once high, done_o stays high until reset. Frame-start and full inputs have no effect on it.
- R8: burst_en_o is low on every lane until done_o rises, and high on every lane while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous transmit digital reset |
| lane_full_i | input | LANES | Per-lane FIFO full flag |
| lane_frame_i | input | LANES | Per-lane frame-start indication |
| burst_en_o | output | LANES | Per-lane frame-burst enable |
| data_valid_o | output | LANES | Per-lane FIFO write enable |
| done_o | output | 1 | Prefill complete, sticky until reset |

## Verification
The bench models lane FIFOs that fill at different rates, so the group becomes full on the slowest lane. A frame pulse sent during filling must be ignored; a design that reacted to it would stop writing before the slow lanes fill. In a second run, one lane's full flag is held low for several cycles after data-valid falls. A design that skipped the full recheck, or counted the settle interval from the frame drop, would raise done too early, and the scoreboard would flag the wrong edge. Resets during filling and after completion test that done and data-valid clear at once and that the start-cycle timing repeats.

// File: rtl/tx_prefill_pkg.sv
package tx_prefill_pkg;
  typedef enum logic [2:0] {
    ST_RESET,
    ST_START,
    ST_FILL,
    ST_WAIT_FRAME,
    ST_STOP_VALID,
    ST_CHECK_FULL,
    ST_SETTLE,
    ST_DONE
  } prefill_state_e;
endpackage

// File: rtl/tx_prefill_lane_sync.sv
module tx_prefill_lane_sync #(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] full_i,
  input  logic [LANES-1:0] frame_i,
  output logic             all_full_o,
  output logic             any_frame_o
);
  logic [LANES-1:0] full_q;
  logic [LANES-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= '0;
      frame_q <= '0;
    end else begin
      full_q  <= full_i;
      frame_q <= frame_i;
    end
  end

  assign all_full_o  = &full_q;
  assign any_frame_o = |frame_q;
endmodule

// File: rtl/tx_prefill_settle.sv
module tx_prefill_settle #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_i && (cnt_q == LAST);

  // settle window must start from zero on each entry
  p_fresh_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !$past(run_i)) |-> (cnt_q == '0));
endmodule

// File: rtl/tx_prefill_fsm.sv
module tx_prefill_fsm
  import tx_prefill_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic all_full_i,
  input  logic any_frame_i,
  input  logic settle_expired_i,
  output logic valid_on_o,
  output logic burst_on_o,
  output logic settle_run_o,
  output logic done_o
);
  prefill_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:      state_d = ST_START;
      ST_START:      state_d = ST_FILL;
      ST_FILL:       if (all_full_i) state_d = ST_WAIT_FRAME;
      ST_WAIT_FRAME: if (any_frame_i) state_d = ST_STOP_VALID;
      ST_STOP_VALID: state_d = ST_CHECK_FULL;
      ST_CHECK_FULL: if (all_full_i) state_d = ST_SETTLE;
      ST_SETTLE:     if (settle_expired_i) state_d = ST_DONE;
      ST_DONE:       state_d = ST_DONE;
      default:       state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign valid_on_o   = (state_q == ST_FILL) || (state_q == ST_WAIT_FRAME);
  assign settle_run_o = (state_q == ST_SETTLE);
  assign done_o       = (state_q == ST_DONE);
  assign burst_on_o   = (state_q == ST_DONE);

  p_fill_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_on_o && !all_full_i && !any_frame_i) |=> valid_on_o);

  p_frame_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_FRAME && any_frame_i) |=> !valid_on_o);

  p_settle_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(settle_run_o) |-> $past(all_full_i));
endmodule

// File: rtl/tx_prefill_ctrl.sv
module tx_prefill_ctrl #(
  parameter int LANES         = 4,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_full_i,
  input  logic [LANES-1:0] lane_frame_i,
  output logic [LANES-1:0] burst_en_o,
  output logic [LANES-1:0] data_valid_o,
  output logic             done_o
);
  logic all_full, any_frame;
  logic valid_on, burst_on, settle_run, settle_expired;

  tx_prefill_lane_sync #(.LANES(LANES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .full_i      (lane_full_i),
    .frame_i     (lane_frame_i),
    .all_full_o  (all_full),
    .any_frame_o (any_frame)
  );

  tx_prefill_fsm u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .all_full_i       (all_full),
    .any_frame_i      (any_frame),
    .settle_expired_i (settle_expired),
    .valid_on_o       (valid_on),
    .burst_on_o       (burst_on),
    .settle_run_o     (settle_run),
    .done_o           (done_o)
  );

  tx_prefill_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (settle_run),
    .expired_o (settle_expired)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane_out
    assign data_valid_o[l] = valid_on;
    assign burst_en_o[l]   = burst_on;
  end

  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  p_no_valid_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (data_valid_o == '0));

  p_burst_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_en_o != '0) |-> done_o);
endmodule

// File: tb/tx_prefill_ctrl_tb_top.sv
module tx_prefill_ctrl_tb_top;
  localparam int LANES  = 4;
  localparam int DEPTH  = 8;
  localparam int SETTLE = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [LANES-1:0] lane_full_i = '0;
  logic [LANES-1:0] lane_frame_i = '0;
  logic [LANES-1:0] burst_en_o;
  logic [LANES-1:0] data_valid_o;
  logic             done_o;

  always #10 clk_i = ~clk_i;

  tx_prefill_ctrl #(.LANES(LANES), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lane_full_i  (lane_full_i),
    .lane_frame_i (lane_frame_i),
    .burst_en_o   (burst_en_o),
    .data_valid_o (data_valid_o),
    .done_o       (done_o)
  );

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int cnt  [LANES];
  int rate [LANES];
  logic [LANES-1:0] leak = '0;
  logic prev_valid = 1'b0;
  logic prev_done  = 1'b0;
  bit   seek = 1'b0;
  int   fall_edge = 0;
  int   exp_fall[$];
  int   exp_done[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // FIFO model + monitor/scoreboard
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      for (int l = 0; l < LANES; l++) cnt[l] = 0;
      lane_full_i = '0;
      prev_valid  = 1'b0;
      prev_done   = 1'b0;
      seek        = 1'b0;
      exp_fall.delete();
      exp_done.delete();
    end else begin
      check(data_valid_o == '0 || data_valid_o == '1, "R5 lane uniform", data_valid_o, 0);
      check(!(done_o && data_valid_o != '0), "R5 valid with done", data_valid_o, 0);
      check(burst_en_o == {LANES{done_o}}, "R8 burst", burst_en_o, {LANES{done_o}});
      if (prev_done && !done_o) check(1'b0, "R7 done dropped", 0, 1);
      if (prev_valid && data_valid_o == '0) begin
        if (exp_fall.size() == 0) check(1'b0, "R4 unexpected valid drop", cyc, -1);
        else begin
          int e;
          e = exp_fall.pop_front();
          check(cyc == e, "R4 drop edge", cyc, e);
        end
        fall_edge = cyc;
        seek = 1'b1;
      end
      if (seek && cyc >= fall_edge + 1 && (&lane_full_i)) begin
        exp_done.push_back(cyc + 1 + SETTLE);
        seek = 1'b0;
      end
      if (!prev_done && done_o) begin
        if (exp_done.size() == 0) check(1'b0, "R6 unexpected done", cyc, -1);
        else begin
          int e;
          e = exp_done.pop_front();
          check(cyc == e, "R6 done edge", cyc, e);
        end
      end
      prev_valid = data_valid_o[0];
      prev_done  = done_o;
      for (int l = 0; l < LANES; l++) begin
        if (data_valid_o[l] && (cyc % rate[l]) == 0 && cnt[l] < DEPTH) cnt[l]++;
        lane_full_i[l] = (cnt[l] >= DEPTH) && !leak[l];
      end
    end
  end

  task automatic do_reset();
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    lane_frame_i = '0;
    leak = '0;
    #1;
    check(data_valid_o == '0, "R1 valid in reset", data_valid_o, 0);
    check(burst_en_o == '0, "R1 burst in reset", burst_en_o, 0);
    check(done_o == 1'b0, "R1 done in reset", done_o, 0);
    repeat (3) @(negedge clk_i);
    #2 rst_ni = 1'b1;
    @(negedge clk_i); #1;
    check(data_valid_o == '0, "R2 start cycle low", data_valid_o, 0);
    @(negedge clk_i); #1;
    check(data_valid_o == '1, "R2 fill begins", data_valid_o, '1);
  endtask

  task automatic run_prefill(input int frame_lane, input int leak_lane, input int leak_len);
    lane_frame_i[frame_lane] = 1'b1;
    @(negedge clk_i); #1 lane_frame_i = '0;
    repeat (2) @(negedge clk_i);
    #1 check(data_valid_o == '1, "R3 early frame ignored", data_valid_o, '1);
    while (!(&lane_full_i)) begin
      @(negedge clk_i); #1;
      check(data_valid_o == '1, "R3 filling", data_valid_o, '1);
    end
    repeat (3) @(negedge clk_i);
    #1 check(data_valid_o == '1, "R4 held without frame", data_valid_o, '1);
    if (leak_len > 0) leak[leak_lane] = 1'b1;
    lane_frame_i[frame_lane] = 1'b1;
    exp_fall.push_back(cyc + 2);
    @(negedge clk_i); #1 lane_frame_i = '0;
    while (data_valid_o != '0) begin
      @(negedge clk_i); #1;
    end
    repeat (leak_len) @(negedge clk_i);
    #1 leak = '0;
    while (!done_o) begin
      @(negedge clk_i); #1;
    end
    check(burst_en_o == '1, "R8 burst with done", burst_en_o, '1);
    for (int i = 0; i < 8; i++) begin
      lane_frame_i = (i % 2 == 0) ? '1 : '0;
      leak = (i % 3 == 0) ? '1 : '0;
      @(negedge clk_i); #1;
      check(done_o == 1'b1 && data_valid_o == '0, "R7 done holds", done_o, 1);
    end
    lane_frame_i = '0;
    leak = '0;
    check(exp_done.size() == 0 && exp_fall.size() == 0, "R6 scoreboard empty",
          exp_done.size() + exp_fall.size(), 0);
  endtask

  initial begin
    rate = '{1, 2, 3, 4};
    do_reset();
    run_prefill(2, 0, 0);
    // reset after done, then a stalled lane during the recheck
    rate = '{3, 1, 4, 2};
    do_reset();
    run_prefill(0, 1, 5);
    // reset in the middle of filling
    rate = '{2, 4, 1, 3};
    do_reset();
    repeat (5) @(negedge clk_i);
    do_reset();
    run_prefill(3, 3, 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule